// File: doc/BRIEF.md
# Trapezoidal Stepper Motion Profile Controller

This block runs one move on a single stepper axis. A move covers a number of steps fixed when the move begins. It follows a trapezoidal speed profile: the speed ramps up, holds at the top rate, ramps down, and then the move ends. The block does not drive the coils. It emits a one-clock step-enable pulse and the latched direction level. A separate phase sequencer turns those into coil patterns.

Speed is a level from 1 to 16. Timing comes from an 8-bit phase accumulator that adds the current level on every clock, and each carry out of the accumulator gives one step. At level 16 the block therefore makes one step every 16 clocks. The build parameter `ACCEL` sets how many step pulses pass between one level change and the next. The block counts the steps it spends accelerating. It starts to slow down once the steps still to go drop to that count or below. A short move therefore turns from ramping up to ramping down without reaching the top speed.

Top module: `stepper_ramp`

## Requirements
- R1: While `rst` is high, on every clock `busy`, `step_en` and `done` are low and no move is in progress.
- R2: On a clock edge where `start` is high, `stop` is low and the block is idle, it captures `nstep` and `dir_in`. `dir_out` shows the captured direction and stays constant for the whole move. Later changes of `dir_in` or `nstep` have no effect on the running move.
- R3: A move with a count N greater than zero issues exactly N `step_en` pulses. Each pulse lasts one clock.
- R4: A move begins at level 1 with the accumulator at zero, so the first step pulse comes 256 clocks after `busy` rises.
- R5: Two step pulses are never closer than 16 clocks apart. A move long enough to reach cruise steps at exactly 16 clocks per step during cruise.
- R6: During acceleration the level rises by one after every `ACCEL` step pulses, up to 16. With `ACCEL`=2 the first five step intervals (busy-to-step, then step-to-step) are 256, 256, 128, 128 and 86 clocks.
- R7: Deceleration begins when the steps still to go are at or below the steps spent accelerating. From then on the level falls by one after every `ACCEL` step pulses, never below 1. A move too short to reach level 16 never steps faster than its peak level allows.
- R8: A completed move raises `done` for exactly one clock, in the same cycle as its final step pulse. `busy` is low in that cycle.
- R9: A start with `nstep`=0 raises `done` one clock after the capturing edge, issues no step pulse and never raises `busy`.
- R10: `stop` high on a clock edge ends any move at that edge. Afterwards `busy` is low and no step pulse or `done` follows. In idle, `stop` takes priority over `start`.
- R11: `start` while a move is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a move (sampled while idle) |
| stop | input | 1 | Abort the current move |
| dir_in | input | 1 | Direction level to capture at start |
| nstep | input | 16 | Step count to capture at start |
| step_en | output | 1 | One-clock pulse per step |
| dir_out | output | 1 | Captured direction of the current/last move |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-clock pulse when a move completes |

## Verification
Each result has a fixed due time. `busy` rises one clock after the capturing edge. The first step comes 256 clocks after that. `done` coincides with the last step. A zero-count `done` arrives one clock after capture. An abort takes effect at the next edge. The bench keeps a free-running cycle count and samples every output on the falling clock edge, so registered results are read a half-cycle after they change. It timestamps each step pulse and compares the intervals with the exact values the accumulator and ramp rules predict. A scoreboard pairs each `done` with the move queued by the driver and checks the step count and direction against it.

// File: rtl/stepper_ramp.sv
module stepper_ramp #(
  parameter int ACCEL = 4,
  parameter int CNT_W = 16,
  parameter int PH_W  = 8,
  parameter int LVL   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             dir_in,
  input  logic [CNT_W-1:0] nstep,
  output logic             step_en,
  output logic             dir_out,
  output logic             busy,
  output logic             done
);
  localparam int LV_W = $clog2(LVL + 1);
  localparam int PR_W = (ACCEL < 2) ? 1 : $clog2(ACCEL);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_CRU, S_DEC} st_t;

  st_t              st;
  logic [CNT_W-1:0] rem, acc_n;
  logic [LV_W-1:0]  lvl;
  logic [PH_W-1:0]  ph;
  logic [PR_W-1:0]  pres;
  logic             dir_q;

  wire [PH_W:0]    sum    = {1'b0, ph} + (PH_W+1)'(lvl);
  wire             carry  = sum[PH_W];
  wire [CNT_W-1:0] rem_nx = rem - 1'b1;
  wire [CNT_W-1:0] acc_nx = acc_n + 1'b1;
  wire             tick   = (pres == PR_W'(ACCEL - 1));
  wire [PR_W-1:0]  pres_nx = tick ? '0 : pres + 1'b1;

  assign busy    = (st != S_IDLE);
  assign dir_out = dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      rem     <= '0;
      acc_n   <= '0;
      lvl     <= LV_W'(1);
      ph      <= '0;
      pres    <= '0;
      dir_q   <= 1'b0;
      step_en <= 1'b0;
      done    <= 1'b0;
    end else begin
      step_en <= 1'b0;
      done    <= 1'b0;
      if (stop) begin
        st <= S_IDLE;
      end else if (st == S_IDLE) begin
        if (start) begin
          dir_q <= dir_in;
          rem   <= nstep;
          acc_n <= '0;
          lvl   <= LV_W'(1);
          ph    <= '0;
          pres  <= '0;
          if (nstep == '0) done <= 1'b1;
          else             st   <= S_ACC;
        end
      end else begin
        ph <= sum[PH_W-1:0];
        if (carry) begin
          step_en <= 1'b1;
          rem     <= rem_nx;
          if (rem_nx == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            case (st)
              S_ACC: begin
                acc_n <= acc_nx;
                if (rem_nx <= acc_nx) begin
                  st   <= S_DEC;
                  pres <= '0;
                end else begin
                  pres <= pres_nx;
                  if (tick) begin
                    if (lvl == LV_W'(LVL)) st  <= S_CRU;
                    else                   lvl <= lvl + 1'b1;
                  end
                end
              end
              S_CRU: begin
                if (rem_nx <= acc_n) begin
                  st   <= S_DEC;
                  pres <= '0;
                end
              end
              default: begin
                pres <= pres_nx;
                if (tick && lvl > LV_W'(1)) lvl <= lvl - 1'b1;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/stepper_ramp_chk.sv
module stepper_ramp_chk (
  input logic clk,
  input logic rst,
  input logic stop,
  input logic step_en,
  input logic dir_out,
  input logic busy,
  input logic done
);
  logic [5:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (step_en) begin
      gap  <= 6'd1;
      seen <= 1'b1;
    end else if (gap != 6'd63) begin
      gap <= gap + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !step_en && !done)); // R1
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> (dir_out == $past(dir_out))); // R2
  AST_STEP_PULSE: assert property (@(posedge clk) disable iff (rst) step_en |=> !step_en); // R3
  AST_STEP_GAP: assert property (@(posedge clk) disable iff (rst) (step_en && seen) |-> (gap >= 6'd16)); // R5
  AST_STEP_IN_MOVE: assert property (@(posedge clk) disable iff (rst) step_en |-> $past(busy)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R8
  AST_STOP_ABORT: assert property (@(posedge clk) disable iff (rst) stop |=> (!busy && !step_en && !done)); // R10
endmodule

bind stepper_ramp stepper_ramp_chk u_chk (
  .clk(clk), .rst(rst), .stop(stop), .step_en(step_en),
  .dir_out(dir_out), .busy(busy), .done(done)
);

// File: tb/tb_stepper_ramp.sv
module tb_stepper_ramp;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, stop = 1'b0, dir_in = 1'b0;
  logic [15:0] nstep = '0;
  logic        step_en, dir_out, busy, done;

  stepper_ramp #(.ACCEL(2)) dut (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .dir_in(dir_in),
    .nstep(nstep), .step_en(step_en), .dir_out(dir_out), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  typedef struct { int n; logic dir; } exp_t;
  exp_t expq[$];
  int   stamps[$];
  int   cyc = 0, n_cmp = 0, n_bad = 0, t_busy = 0, mon_cnt = 0;
  logic busy_d = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (busy && !busy_d) begin
        t_busy = cyc;
        stamps.delete();
        mon_cnt = 0;
      end
      if (step_en) begin
        mon_cnt++;
        stamps.push_back(cyc);
      end
      if (done) begin
        if (expq.size() == 0) chk(0, "R10", "done with no move pending", 1, 0);
        else begin
          exp_t e;
          e = expq.pop_front();
          chk(mon_cnt == e.n, "R3", "step count", mon_cnt, e.n);
          chk(dir_out == e.dir, "R2", "direction", int'(dir_out), int'(e.dir));
          chk(!busy, "R8", "busy low with done", int'(busy), 0);
          if (e.n > 0) chk(step_en, "R8", "done with final step", int'(step_en), 1);
        end
        mon_cnt = 0;
      end else if (!busy) mon_cnt = 0;
      busy_d = busy;
    end
  end

  task automatic go(int n, logic d, bit expect_done);
    @(negedge clk);
    nstep = 16'(n);
    dir_in = d;
    start = 1'b1;
    if (expect_done) begin
      exp_t e;
      e.n = n;
      e.dir = d;
      expq.push_back(e);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic gaps(output int mn, output int n16, output int last);
    mn = 1000000; n16 = 0; last = 0;
    for (int i = 1; i < stamps.size(); i++) begin
      int g;
      g = stamps[i] - stamps[i-1];
      if (g < mn) mn = g;
      if (g == 16) n16++;
      last = g;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int mn, n16, last, cnt;
    repeat (3) @(negedge clk);
    chk(!busy && !step_en && !done, "R1", "outputs in reset", int'({busy, step_en, done}), 0);
    @(negedge clk);
    rst = 1'b0;

    // ramp-up timing, latch of inputs
    go(40, 1'b1, 1'b1);
    dir_in = 1'b0;
    nstep = 16'd3;
    repeat (300) @(negedge clk);
    chk(dir_out == 1'b1, "R2", "dir_out mid-move", int'(dir_out), 1);
    wait_idle();
    chk(stamps.size() == 40, "R3", "stamps recorded", stamps.size(), 40);
    chk(stamps[0] - t_busy == 256, "R4", "first step delay", stamps[0] - t_busy, 256);
    chk(stamps[1] - stamps[0] == 256, "R6", "interval 2", stamps[1] - stamps[0], 256);
    chk(stamps[2] - stamps[1] == 128, "R6", "interval 3", stamps[2] - stamps[1], 128);
    chk(stamps[3] - stamps[2] == 128, "R6", "interval 4", stamps[3] - stamps[2], 128);
    chk(stamps[4] - stamps[3] == 86, "R6", "interval 5", stamps[4] - stamps[3], 86);

    // long move reaches cruise
    go(400, 1'b0, 1'b1);
    wait_idle();
    gaps(mn, n16, last);
    chk(mn == 16, "R5", "minimum interval", mn, 16);
    chk(n16 >= 100, "R5", "cruise intervals at 16", n16, 100);
    chk(last > 64, "R7", "final interval after ramp-down", last, 65);

    // short move never cruises
    go(10, 1'b1, 1'b1);
    wait_idle();
    gaps(mn, n16, last);
    chk(mn > 32, "R7", "short move minimum interval", mn, 33);
    chk(last > 64, "R7", "short move final interval", last, 65);

    // start during a move is ignored
    go(50, 1'b1, 1'b1);
    repeat (1000) @(negedge clk);
    nstep = 16'd7;
    dir_in = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R11", "still busy after extra start", int'(busy), 1);
    wait_idle();

    // zero-length move
    go(0, 1'b0, 1'b1);
    chk(done && !busy, "R9", "zero move done at once", int'({done, busy}), 2);
    @(negedge clk);
    chk(!done && !busy, "R9", "zero move idle after", int'({done, busy}), 0);

    // abort
    go(300, 1'b1, 1'b0);
    repeat (800) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!busy && !step_en, "R10", "abort state", int'({busy, step_en}), 0);
    cnt = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (step_en || done || busy) cnt++;
    end
    chk(cnt == 0, "R10", "activity after abort", cnt, 0);

    // stop beats start in idle
    nstep = 16'd5;
    start = 1'b1;
    stop = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy, "R10", "stop over start", int'(busy), 0);

    // single-step move
    go(1, 1'b0, 1'b1);
    wait_idle();
    chk(stamps.size() == 1, "R3", "single step count", stamps.size(), 1);
    chk(stamps[0] - t_busy == 256, "R4", "single step delay", stamps[0] - t_busy, 256);

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R8", "moves without done", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule